// File: doc/BRIEF.md
# Mid-Band Sign Watermark Embedder and Extractor

This block hides one watermark bit in a 4x4 block of signed transform coefficients, or reads that bit back. Coefficients arrive as 16 beats in raster order over a valid/ready input. The operation mode, the watermark bit and an unsigned Q4.4 weighting factor are sampled together with the first beat of each block.

In embed mode the block first works out a strength threshold from the block itself. The threshold is the weighting factor times the summed magnitude of the 15 AC coefficients, divided by 16, and saturated to the largest positive coefficient. The three coefficients on the second anti-diagonal get the watermark bit as their sign, and their magnitude is raised to at least the threshold. The whole block then streams out in raster order. In extract mode the block reads the signs of the same three positions and gives the majority as a one-cycle bit result, with no coefficient output. Extraction needs neither the original cover image nor the weighting factor.

Top module: `wm_midband_embed`

## Requirements
- R1: When idle, in_ready_o is high. A block is 16 accepted beats in raster order (index = row*4 + column), and bubbles between beats are allowed. mode_i (0 = embed, 1 = extract), bit_i and alpha_i are sampled only on the block's first beat.
- R2: From the cycle after the 16th beat is accepted, in_ready_o stays low until the block's result is finished. In embed mode that is through the last output beat. In extract mode it is through the cycle before the bit pulse.
- R3: The embed threshold is Th = min(floor(alpha * S / 256), 32767). S is the sum of |c| over the 15 coefficients other than index 0, and alpha is the 8-bit unsigned Q4.4 value.
- R4: In embed mode the coefficients at indices 2, 5 and 8 become min(max(|c|, Th), 32767) for bit 1 and -max(|c|, Th) for bit 0.
- R5: In embed mode all other coefficients, including index 0, are output unchanged.
- R6: In embed mode the output is 16 contiguous beats on out_valid_o, in raster order. Beat 0 appears in the second cycle after the clock edge that accepted the last input beat.
- R7: In extract mode bit_valid_o pulses for one cycle, in the second cycle after the last input beat, and out_valid_o stays low. bit_o is 1 only when at least two of indices 2, 5 and 8 are strictly positive, so a zero coefficient reads as 0.
- R8: An embedded block with Th > 0, when fed back in extract mode, returns the embedded bit.
- R9: After reset, in_ready_o is 1 and out_valid_o and bit_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input coefficient beat valid |
| in_ready_o | output | 1 | Block can accept an input beat |
| in_coef_i | input | 16 | Signed input coefficient |
| mode_i | input | 1 | 0 embed, 1 extract; sampled on the first beat |
| bit_i | input | 1 | Watermark bit to embed; sampled on the first beat |
| alpha_i | input | 8 | Unsigned Q4.4 weighting factor; sampled on the first beat |
| out_valid_o | output | 1 | Output coefficient beat valid (embed) |
| out_coef_o | output | 16 | Signed output coefficient |
| bit_valid_o | output | 1 | One-cycle pulse with the extracted bit |
| bit_o | output | 1 | Extracted watermark bit |

## Verification
A fault in the beat counter or the coefficient buffer shows up in the output burst of the same block. Coefficients land at the wrong raster index, pass-through values change, or the burst does not have 16 beats. A fault in the magnitude accumulator or the threshold scaling appears only at indices 2, 5 and 8. It shows once the threshold exceeds the original magnitudes, so large weighting factors with small coefficients bring it out within one block. Mode or bit sampling faults show up as a missing stream, a wrong pulse or a flipped sign in the very next result.

// File: rtl/wm_pkg.sv
package wm_pkg;
  typedef enum logic [1:0] {ST_LOAD, ST_CALC, ST_EMIT} wm_state_e;

  // Raster index lies on the selected anti-diagonal
  function automatic logic is_mid_pos(int unsigned idx, int unsigned blk_n, int unsigned diag);
    return ((idx / blk_n) + (idx % blk_n)) == diag;
  endfunction

  function automatic int unsigned mid_count(int unsigned blk_n, int unsigned diag);
    int unsigned n = 0;
    for (int unsigned i = 0; i < blk_n * blk_n; i++)
      if (is_mid_pos(i, blk_n, diag)) n++;
    return n;
  endfunction
endpackage

// File: rtl/wm_thresh.sv
module wm_thresh #(
  parameter int unsigned COEF_W     = 16,
  parameter int unsigned ALPHA_W    = 8,
  parameter int unsigned ALPHA_FRAC = 4,
  parameter int unsigned NCOEF      = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     acc_en_i,
  input  logic                     acc_clr_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic [ALPHA_W-1:0]       alpha_i,
  output logic [COEF_W-1:0]        th_o
);
  localparam int unsigned SUM_W  = COEF_W + $clog2(NCOEF);
  localparam int unsigned PROD_W = SUM_W + ALPHA_W;
  localparam int unsigned SHIFT  = ALPHA_FRAC + $clog2(NCOEF);
  localparam logic [COEF_W-1:0] TH_MAX = {1'b0, {(COEF_W-1){1'b1}}};

  logic [COEF_W-1:0] mag;
  logic [SUM_W-1:0]  acc_q;
  logic [PROD_W-1:0] prod, scaled;

  assign mag = coef_i[COEF_W-1] ? (~coef_i + 1'b1) : coef_i;

  // DC beat clears the sum instead of adding to it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (acc_en_i) acc_q <= acc_clr_i ? '0 : acc_q + SUM_W'(mag);
  end

  assign prod   = PROD_W'(acc_q) * PROD_W'(alpha_i);
  assign scaled = prod >> SHIFT;
  assign th_o   = (scaled > PROD_W'(TH_MAX)) ? TH_MAX : scaled[COEF_W-1:0];
endmodule

// File: rtl/wm_coef_mod.sv
module wm_coef_mod #(
  parameter int unsigned COEF_W = 16
) (
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic [COEF_W-1:0]        th_i,
  input  logic                     bit_i,
  input  logic                     sel_i,
  output logic signed [COEF_W-1:0] coef_o
);
  localparam logic [COEF_W-1:0] POS_MAX = {1'b0, {(COEF_W-1){1'b1}}};

  logic [COEF_W-1:0] mag, big, pos, neg;

  assign mag = coef_i[COEF_W-1] ? (~coef_i + 1'b1) : coef_i;
  assign big = (mag > th_i) ? mag : th_i;
  assign pos = (big > POS_MAX) ? POS_MAX : big;
  assign neg = ~big + 1'b1;

  always_comb begin
    if (!sel_i)     coef_o = coef_i;
    else if (bit_i) coef_o = $signed(pos);
    else            coef_o = $signed(neg);
  end
endmodule

// File: rtl/wm_vote.sv
module wm_vote import wm_pkg::*; #(
  parameter int unsigned COEF_W   = 16,
  parameter int unsigned BLK_N    = 4,
  parameter int unsigned MID_DIAG = 2,
  localparam int unsigned NCOEF   = BLK_N * BLK_N
) (
  input  logic signed [COEF_W-1:0] blk_i [NCOEF],
  output logic                     bit_o
);
  localparam int unsigned NMID = mid_count(BLK_N, MID_DIAG);

  logic [NCOEF-1:0] vote;

  for (genvar i = 0; i < NCOEF; i++) begin : g_vote
    if (is_mid_pos(i, BLK_N, MID_DIAG)) begin : g_mid
      assign vote[i] = !blk_i[i][COEF_W-1] && (blk_i[i] != '0);
    end else begin : g_other
      assign vote[i] = 1'b0;
    end
  end

  assign bit_o = $countones(vote) > (NMID / 2);
endmodule

// File: rtl/wm_midband_embed.sv
module wm_midband_embed import wm_pkg::*; #(
  parameter int unsigned COEF_W     = 16,
  parameter int unsigned ALPHA_W    = 8,
  parameter int unsigned ALPHA_FRAC = 4,
  parameter int unsigned BLK_N      = 4,
  parameter int unsigned MID_DIAG   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic signed [COEF_W-1:0] in_coef_i,
  input  logic                     mode_i,
  input  logic                     bit_i,
  input  logic [ALPHA_W-1:0]       alpha_i,
  output logic                     out_valid_o,
  output logic signed [COEF_W-1:0] out_coef_o,
  output logic                     bit_valid_o,
  output logic                     bit_o
);
  localparam int unsigned NCOEF = BLK_N * BLK_N;
  localparam int unsigned IDX_W = $clog2(NCOEF);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NCOEF - 1);

  wm_state_e             state_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  mode_q, bit_q, vote_q, vote_vld_q, vote;
  logic [ALPHA_W-1:0]    alpha_q;
  logic [COEF_W-1:0]     th, th_q;
  logic signed [COEF_W-1:0] buf_q [NCOEF];
  logic [NCOEF-1:0]      mid_mask;
  logic                  in_hs, first_beat;

  for (genvar i = 0; i < NCOEF; i++) begin : g_mask
    assign mid_mask[i] = is_mid_pos(i, BLK_N, MID_DIAG);
  end

  assign in_ready_o = (state_q == ST_LOAD);
  assign in_hs      = in_valid_i && in_ready_o;
  assign first_beat = (idx_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_LOAD;
      idx_q      <= '0;
      mode_q     <= 1'b0;
      bit_q      <= 1'b0;
      alpha_q    <= '0;
      th_q       <= '0;
      vote_q     <= 1'b0;
      vote_vld_q <= 1'b0;
    end else begin
      vote_vld_q <= 1'b0;
      unique case (state_q)
        ST_LOAD: if (in_hs) begin
          if (first_beat) begin
            mode_q  <= mode_i;
            bit_q   <= bit_i;
            alpha_q <= alpha_i;
          end
          if (idx_q == IDX_LAST) begin
            idx_q   <= '0;
            state_q <= ST_CALC;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_CALC: begin
          th_q <= th;
          if (mode_q) begin
            vote_q     <= vote;
            vote_vld_q <= 1'b1;
            state_q    <= ST_LOAD;
          end else begin
            state_q <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (idx_q == IDX_LAST) begin
            idx_q   <= '0;
            state_q <= ST_LOAD;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (in_hs) buf_q[idx_q] <= in_coef_i;
  end

  // Alpha is needed only in ST_CALC, after alpha_q holds the first-beat value
  wm_thresh #(
    .COEF_W(COEF_W), .ALPHA_W(ALPHA_W), .ALPHA_FRAC(ALPHA_FRAC), .NCOEF(NCOEF)
  ) u_thresh (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_en_i (in_hs),
    .acc_clr_i(first_beat),
    .coef_i   (in_coef_i),
    .alpha_i  (alpha_q),
    .th_o     (th)
  );

  wm_vote #(.COEF_W(COEF_W), .BLK_N(BLK_N), .MID_DIAG(MID_DIAG)) u_vote (
    .blk_i(buf_q),
    .bit_o(vote)
  );

  wm_coef_mod #(.COEF_W(COEF_W)) u_mod (
    .coef_i(buf_q[idx_q]),
    .th_i  (th_q),
    .bit_i (bit_q),
    .sel_i (mid_mask[idx_q]),
    .coef_o(out_coef_o)
  );

  assign out_valid_o = (state_q == ST_EMIT);
  assign bit_valid_o = vote_vld_q;
  assign bit_o       = vote_q;
endmodule

// File: rtl/wm_midband_embed_chk.sv
module wm_midband_embed_chk import wm_pkg::*; #(
  parameter int unsigned COEF_W   = 16,
  parameter int unsigned BLK_N    = 4,
  parameter int unsigned MID_DIAG = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     in_valid_i,
  input logic                     in_ready_o,
  input logic signed [COEF_W-1:0] in_coef_i,
  input logic                     bit_i,
  input logic                     out_valid_o,
  input logic signed [COEF_W-1:0] out_coef_o,
  input logic                     bit_valid_o
);
  localparam int unsigned NCOEF = BLK_N * BLK_N;
  localparam int unsigned IDX_W = $clog2(NCOEF);

  logic [IDX_W-1:0]         icnt_q;
  logic [IDX_W:0]           ocnt_q;
  logic                     ebit_q;
  logic signed [COEF_W-1:0] sh_q [NCOEF];
  logic [NCOEF-1:0]         mid_mask;
  logic                     cur_mid;
  logic signed [COEF_W-1:0] cur_sh;

  for (genvar i = 0; i < NCOEF; i++) begin : g_mask
    assign mid_mask[i] = is_mid_pos(i, BLK_N, MID_DIAG);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icnt_q <= '0;
      ocnt_q <= '0;
      ebit_q <= 1'b0;
    end else begin
      if (in_valid_i && in_ready_o) begin
        icnt_q <= icnt_q + 1'b1;
        if (icnt_q == '0) ebit_q <= bit_i;
      end
      ocnt_q <= out_valid_o ? ocnt_q + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (in_valid_i && in_ready_o) sh_q[icnt_q] <= in_coef_i;
  end

  assign cur_mid = mid_mask[ocnt_q[IDX_W-1:0]];
  assign cur_sh  = sh_q[ocnt_q[IDX_W-1:0]];

  a_r2_busy_while_emitting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);
  a_r7_no_stream_with_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_valid_o && bit_valid_o));
  a_r6_burst_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (ocnt_q < (IDX_W+1)'(NCOEF)));
  a_r6_burst_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_o) |-> (ocnt_q == (IDX_W+1)'(NCOEF)));
  a_r5_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !cur_mid) |-> (out_coef_o == cur_sh));
  a_r4_sign_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && cur_mid && ebit_q) |-> !out_coef_o[COEF_W-1]);
  a_r4_sign_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && cur_mid && !ebit_q) |-> (out_coef_o[COEF_W-1] || out_coef_o == '0));
endmodule

bind wm_midband_embed wm_midband_embed_chk #(
  .COEF_W(COEF_W), .BLK_N(BLK_N), .MID_DIAG(MID_DIAG)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .in_coef_i  (in_coef_i),
  .bit_i      (bit_i),
  .out_valid_o(out_valid_o),
  .out_coef_o (out_coef_o),
  .bit_valid_o(bit_valid_o)
);

// File: tb/wm_midband_embed_test.sv
`timescale 1ns/1ps
module wm_midband_embed_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, mode = 1'b0, wbit = 1'b0, out_valid, bit_valid, bit_out, in_ready;
  logic signed [15:0] in_coef = '0, out_coef;
  logic [7:0] alpha = '0;
  int tests = 0, fails = 0;
  int cur[16];
  int got[16];

  always #4 clk = ~clk;

  wm_midband_embed uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_coef_i(in_coef), .mode_i(mode), .bit_i(wbit), .alpha_i(alpha),
    .out_valid_o(out_valid), .out_coef_o(out_coef), .bit_valid_o(bit_valid), .bit_o(bit_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_mid(int i);
    return i == 2 || i == 5 || i == 8;
  endfunction

  function automatic int iabs(int v);
    return v < 0 ? -v : v;
  endfunction

  function automatic int exp_th(int a);
    int s = 0, t;
    for (int i = 1; i < 16; i++) s += iabs(cur[i]);
    t = (a * s) / 256;
    return t > 32767 ? 32767 : t;
  endfunction

  function automatic int exp_coef(int i, int th, int b);
    int big;
    if (!is_mid(i)) return cur[i];
    big = iabs(cur[i]) > th ? iabs(cur[i]) : th;
    if (b != 0) return big > 32767 ? 32767 : big;
    return -big;
  endfunction

  function automatic int exp_vote();
    int n = 0;
    if (cur[2] > 0) n++;
    if (cur[5] > 0) n++;
    if (cur[8] > 0) n++;
    return n >= 2 ? 1 : 0;
  endfunction

  // Drive one block from a negedge; later beats carry inverted side inputs (R1 sampling)
  task automatic send_block(input int md, input int b, input int a, input bit bubbles);
    for (int i = 0; i < 16; i++) begin
      if (bubbles && $urandom_range(0, 3) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_coef  = 16'(cur[i]);
      mode     = (i == 0) ? md[0] : ~md[0];
      wbit     = (i == 0) ? b[0] : ~b[0];
      alpha    = (i == 0) ? 8'(a) : ~8'(a);
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(!in_ready, "R2 ready low after last beat", in_ready, 0);
    chk(!out_valid && !bit_valid, "R6 R7 no result in first cycle", out_valid, 0);
    @(negedge clk);
  endtask

  task automatic run_embed(input int b, input int a, input bit bubbles);
    int th;
    send_block(0, b, a, bubbles);
    th = exp_th(a);
    for (int k = 0; k < 16; k++) begin
      got[k] = int'(out_coef);
      chk(out_valid, "R6 output beat valid", out_valid, 1);
      chk(!in_ready, "R2 ready low while emitting", in_ready, 0);
      if (is_mid(k)) chk(got[k] == exp_coef(k, th, b), "R3 R4 mid coefficient", got[k], exp_coef(k, th, b));
      else chk(got[k] == cur[k], "R5 passthrough coefficient", got[k], cur[k]);
      @(negedge clk);
    end
    chk(!out_valid, "R6 burst ends after 16 beats", out_valid, 0);
    chk(in_ready, "R2 ready back after burst", in_ready, 1);
  endtask

  task automatic run_extract(input int a, output int res);
    send_block(1, $urandom_range(0, 1), a, 1'b1);
    chk(bit_valid, "R7 bit pulse in second cycle", bit_valid, 1);
    chk(!out_valid, "R7 no coefficient stream", out_valid, 0);
    chk(int'(bit_out) == exp_vote(), "R7 majority of positive signs", bit_out, exp_vote());
    chk(in_ready, "R2 ready during bit pulse", in_ready, 1);
    res = int'(bit_out);
    @(negedge clk);
    chk(!bit_valid, "R7 pulse lasts one cycle", bit_valid, 0);
  endtask

  function automatic int rnd_coef(bit wide);
    if (wide) return int'($urandom_range(0, 65535)) - 32768;
    return int'($urandom_range(0, 400)) - 200;
  endfunction

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int r, th, b, a;
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    chk(in_ready, "R9 reset ready", in_ready, 1);
    chk(!out_valid, "R9 reset out_valid", out_valid, 0);
    chk(!bit_valid, "R9 reset bit_valid", bit_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Zero block, zero threshold; zero reads back as 0 (R7)
    for (int i = 0; i < 16; i++) cur[i] = 0;
    run_embed(1, 16, 1'b0);
    run_extract(16, r);
    chk(r == 0, "R7 zero coefficients read as 0", r, 0);

    // Saturated threshold and magnitude clip (R3, R4)
    for (int i = 0; i < 16; i++) cur[i] = is_mid(i) ? -32768 : 32767;
    run_embed(1, 255, 1'b0);
    run_embed(0, 255, 1'b0);
    // Threshold dominates small coefficients; DC excluded from the sum (R3)
    for (int i = 0; i < 16; i++) cur[i] = (i == 0) ? 30000 : ((i % 2) ? 100 : -100);
    run_embed(1, 8'h30, 1'b1);
    run_embed(0, 8'h08, 1'b1);

    // Vote corner cases (R7)
    for (int i = 0; i < 16; i++) cur[i] = 1000;
    cur[2] = 5; cur[5] = -3; cur[8] = 0;
    run_extract(0, r);
    cur[2] = 5; cur[5] = 7; cur[8] = 0;
    run_extract(0, r);
    cur[2] = -1; cur[5] = 1; cur[8] = 1;
    run_extract(0, r);

    // Random embed followed by blind re-extraction
    for (int n = 0; n < 40; n++) begin
      bit wide = (n % 3 == 0);
      for (int i = 0; i < 16; i++) cur[i] = rnd_coef(wide);
      b = $urandom_range(0, 1);
      a = $urandom_range(0, 255);
      th = exp_th(a);
      run_embed(b, a, 1'b1);
      for (int i = 0; i < 16; i++) cur[i] = got[i];
      run_extract($urandom_range(0, 255), r);
      if (th > 0) chk(r == b, "R8 blind round trip", r, b);
    end

    // Random extraction
    for (int n = 0; n < 20; n++) begin
      for (int i = 0; i < 16; i++) cur[i] = rnd_coef(n[0]);
      run_extract(0, r);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule